// File: doc/BRIEF.md
# Burst PSRAM WAIT Generator

This block is the memory-side controller that decides, clock by clock, whether a burst-capable pseudo-static RAM drives its WAIT pin during synchronous bursts. A burst opens when chip enable is low and the address-valid strobe is sampled low at a clock edge. From then on the block counts the initial access latency, delays the first word while an internal refresh is busy (variable-latency mode only), and stalls the burst each time the linear word address wraps past the end of a 128-word row. For every cycle in which a word moves it raises a read-valid or write-accept strobe to the array datapath and presents the word address.

Two configuration inputs shape the pin. One picks fixed or variable initial latency. The other picks whether WAIT lines up with the stall cycles or runs one clock ahead of them. WAIT is active high. The refresh timer, the cell array and the configuration register are outside the block. During asynchronous or page accesses the pin carries no meaning, and the block models no such accesses.

Top module: `psram_wait_gen`

## Requirements
- R1: A burst starts at a clock edge where `ce_n`=0 and `adv_n`=0. With `cfg_wait_early`=0, `wait_o` is 1 for the next max(`cfg_lat_cnt`,1) cycles and no strobe is raised in those cycles.
- R2: After the initial stall, exactly one word moves on each cycle, and its strobe is high. `data_addr_o` starts at the captured address and grows by one per word.
- R3: `we_n` is captured at burst start. A burst opened with `we_n`=0 raises only `wr_accept_o`, and a burst opened with `we_n`=1 raises only `rd_valid_o`.
- R4: With `cfg_fixed_lat`=0, each initial-latency cycle in which `refresh_busy`=1 is not counted. The stall therefore grows by one cycle for each busy cycle.
- R5: With `cfg_wait_early`=1, `wait_o` is 1 in the cycle before each stall cycle rather than in the stall cycle itself. WAIT rises one cycle before the stall begins and falls one cycle before the first word after it.
- R6: With `cfg_fixed_lat`=1, `refresh_busy` does not lengthen the initial latency.
- R7: After the word whose low 7 address bits are all ones, the burst stalls for max(`cfg_lat_cnt`,1) cycles with WAIT active. It then resumes at the next address, whose low 7 bits are zero.
- R8: During a row-crossing stall, in either latency mode, each cycle with `refresh_busy`=1 is not counted.
- R9: When `ce_n` is sampled high, the burst ends. On the next cycle `wait_o`, `rd_valid_o` and `wr_accept_o` are all 0.
- R10: `adv_n`=0 with `ce_n`=0 during a burst restarts it at the new address, with a fresh initial latency.
- R11: A `cfg_lat_cnt` of 0 behaves as a latency of 1.
- R12: After reset, with `ce_n` high, `wait_o` and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low; starts a burst |
| we_n | input | 1 | Write enable, active low, sampled at burst start |
| addr_i | input | ADDR_W | Word address captured at burst start |
| cfg_wait_early | input | 1 | 1: WAIT runs one cycle ahead of the stall cycles |
| cfg_fixed_lat | input | 1 | 1: fixed initial latency that hides refresh |
| cfg_lat_cnt | input | LAT_W | Latency cycle count for the initial and row-crossing stalls |
| refresh_busy | input | 1 | Internal refresh in progress |
| wait_o | output | 1 | WAIT pin, active high |
| rd_valid_o | output | 1 | Read word valid this cycle |
| wr_accept_o | output | 1 | Write word accepted this cycle |
| data_addr_o | output | ADDR_W | Address of the word moving this cycle |

## Verification
The embedded properties watch the local rules on every cycle. Chip-enable high empties the burst. The word address steps by one per transfer. A refresh-held counter keeps its value. Fixed mode counts down regardless of refresh. The all-ones row word leads into a stall, and in aligned mode WAIT never coincides with a transfer. Only the directed scenarios can show the absolute cycle counts: the length of the initial and row stalls, the extra cycles added by a refresh collision, the one-cycle lead in early mode, the zero-latency clamp, and where a restart resumes.

// File: rtl/psram_wait_pkg.sv
// Package: shared types for the burst WAIT generator.
// Assumes: one burst phase is active at a time.
package psram_wait_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // no burst open
        PH_LAT  = 2'd1,   // initial access latency
        PH_XFER = 2'd2,   // one word per cycle
        PH_ROW  = 2'd3    // row-crossing stall
    } burst_phase_t;
endpackage

// File: rtl/psram_stall_counter.sv
// Module: down-counter that times one stall (initial latency or row crossing).
// Assumes: load and active are never both meaningful in one cycle (load wins).
// done flags the last stall cycle; a held cycle is never the last one.
module psram_stall_counter #(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] load_val,
    input  logic             active,
    input  logic             hold,
    output logic [LAT_W-1:0] cnt,
    output logic             done
);
    logic [LAT_W-1:0] cnt_q;

    // Purpose: load on stall entry, count down while a stall runs unheld.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (active && !hold && (cnt_q > LAT_W'(1)))
            cnt_q <= cnt_q - 1'b1;
    end

    // Purpose: flag the final cycle of an unheld stall.
    always_comb done = active && !hold && (cnt_q <= LAT_W'(1));

    assign cnt = cnt_q;

    // A refresh-held stall cycle leaves the count untouched.
    assert_hold_keeps_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && hold && !load) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/psram_burst_addr.sv
// Module: linear burst word-address counter with row-end detection.
// Assumes: rows are 2**ROW_BITS words; the address wraps modulo 2**ADDR_W.
module psram_burst_addr #(
    parameter int ADDR_W   = 22,
    parameter int ROW_BITS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              row_last
);
    localparam logic [ROW_BITS-1:0] ROW_END = '1;

    logic [ADDR_W-1:0] addr_q;

    // Purpose: capture the start address, then step once per moved word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (load)
            addr_q <= load_addr;
        else if (inc)
            addr_q <= addr_q + 1'b1;
    end

    // Purpose: flag the last word of a row.
    always_comb row_last = (addr_q[ROW_BITS-1:0] == ROW_END);

    assign addr = addr_q;

    // Each moved word advances the address by exactly one.
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (addr_q == $past(addr_q) + 1'b1));
endmodule

// File: rtl/psram_burst_fsm.sv
// Module: burst phase sequencer.
// Assumes: the stall counter reports stall_done on the final unheld stall cycle.
// Chip-enable high always wins; an address strobe under chip enable restarts.
module psram_burst_fsm
    import psram_wait_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce_n,
    input  logic         adv_n,
    input  logic         stall_done,
    input  logic         row_last,
    output burst_phase_t phase,
    output burst_phase_t phase_next,
    output logic         start,
    output logic         row_enter
);
    burst_phase_t phase_q, phase_d;

    // Purpose: detect burst start and the step into a row stall.
    always_comb begin
        start     = !ce_n && !adv_n;
        row_enter = !ce_n && adv_n && (phase_q == PH_XFER) && row_last;
    end

    // Purpose: choose the next burst phase.
    always_comb begin
        phase_d = phase_q;
        if (ce_n)
            phase_d = PH_IDLE;
        else if (!adv_n)
            phase_d = PH_LAT;
        else begin
            unique case (phase_q)
                PH_IDLE: phase_d = PH_IDLE;
                PH_LAT:  phase_d = stall_done ? PH_XFER : PH_LAT;
                PH_ROW:  phase_d = stall_done ? PH_XFER : PH_ROW;
                PH_XFER: phase_d = row_last ? PH_ROW : PH_XFER;
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // Purpose: phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= PH_IDLE;
        else
            phase_q <= phase_d;
    end

    assign phase      = phase_q;
    assign phase_next = phase_d;

    // Chip enable high leaves no burst open on the next cycle.
    assert_ce_high_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (phase_q == PH_IDLE));

    // The last word of a row is followed by a row stall.
    assert_row_end_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && adv_n && phase_q == PH_XFER && row_last) |=> (phase_q == PH_ROW));
endmodule

// File: rtl/psram_wait_gen.sv
// Module: top of the burst WAIT generator.
// Assumes: configuration inputs are steady while a burst is open.
// WAIT is active high. It follows the stall phases, or runs one cycle ahead of
// them (taken from the next phase) when cfg_wait_early is set.
module psram_wait_gen
    import psram_wait_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int ROW_BITS = 7,
    parameter int LAT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cfg_wait_early,
    input  logic              cfg_fixed_lat,
    input  logic [LAT_W-1:0]  cfg_lat_cnt,
    input  logic              refresh_busy,
    output logic              wait_o,
    output logic              rd_valid_o,
    output logic              wr_accept_o,
    output logic [ADDR_W-1:0] data_addr_o
);
    burst_phase_t     phase, phase_next;
    logic             start, row_enter;
    logic             stall_done, stall_active, stall_hold;
    logic [LAT_W-1:0] stall_cnt, lat_load;
    logic             row_last, xfer;
    logic             is_write_q;

    // Purpose: clamp a zero latency setting to one cycle.
    always_comb lat_load = (cfg_lat_cnt == '0) ? LAT_W'(1) : cfg_lat_cnt;

    // Purpose: decide when the stall counter runs and when refresh holds it.
    always_comb begin
        stall_active = (phase == PH_LAT) || (phase == PH_ROW);
        stall_hold   = refresh_busy &&
                       ((phase == PH_ROW) || ((phase == PH_LAT) && !cfg_fixed_lat));
    end

    psram_burst_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .adv_n      (adv_n),
        .stall_done (stall_done),
        .row_last   (row_last),
        .phase      (phase),
        .phase_next (phase_next),
        .start      (start),
        .row_enter  (row_enter)
    );

    psram_stall_counter #(.LAT_W(LAT_W)) u_stall (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start || row_enter),
        .load_val (lat_load),
        .active   (stall_active),
        .hold     (stall_hold),
        .cnt      (stall_cnt),
        .done     (stall_done)
    );

    // Purpose: one word moves per transfer-phase cycle.
    always_comb xfer = (phase == PH_XFER);

    psram_burst_addr #(.ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_addr (addr_i),
        .inc       (xfer),
        .addr      (data_addr_o),
        .row_last  (row_last)
    );

    // Purpose: remember the burst direction captured at start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            is_write_q <= 1'b0;
        else if (start)
            is_write_q <= !we_n;
    end

    // Purpose: drive WAIT and the datapath strobes.
    always_comb begin
        if (cfg_wait_early)
            wait_o = (phase_next == PH_LAT) || (phase_next == PH_ROW);
        else
            wait_o = stall_active;
        rd_valid_o  = xfer && !is_write_q;
        wr_accept_o = xfer &&  is_write_q;
    end

    // Fixed latency counts down even while refresh is busy.
    assert_fixed_ignores_refresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LAT && cfg_fixed_lat && !ce_n && adv_n && stall_cnt > LAT_W'(1))
        |=> (phase == PH_LAT && stall_cnt == $past(stall_cnt) - 1'b1));

    // Variable latency stays in the initial stall while refresh is busy.
    assert_var_refresh_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LAT && !cfg_fixed_lat && refresh_busy && !ce_n && adv_n)
        |=> (phase == PH_LAT));

    // In aligned mode WAIT and a word transfer never share a cycle.
    assert_wait_excludes_xfer_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wait_early |-> !(wait_o && (rd_valid_o || wr_accept_o)));
endmodule

// File: tb/tb_psram_wait_gen.sv
// Directed bench: one task per scenario, each checking its own cycle records.
module tb_psram_wait_gen;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 22;
    localparam int LAT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ce_n, adv_n, we_n;
    logic [ADDR_W-1:0] addr_i;
    logic              cfg_wait_early, cfg_fixed_lat;
    logic [LAT_W-1:0]  cfg_lat_cnt;
    logic              refresh_busy;
    logic              wait_o, rd_valid_o, wr_accept_o;
    logic [ADDR_W-1:0] data_addr_o;

    int n_vec  = 0;
    int n_fail = 0;

    logic              r_wait [32];
    logic              r_rd   [32];
    logic              r_wr   [32];
    logic [ADDR_W-1:0] r_addr [32];

    always #(CLK_P/2) clk = ~clk;

    psram_wait_gen dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
        .addr_i(addr_i), .cfg_wait_early(cfg_wait_early), .cfg_fixed_lat(cfg_fixed_lat),
        .cfg_lat_cnt(cfg_lat_cnt), .refresh_busy(refresh_busy), .wait_o(wait_o),
        .rd_valid_o(rd_valid_o), .wr_accept_o(wr_accept_o), .data_addr_o(data_addr_o)
    );

    task automatic chk(input string req, input int cyc, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: got %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Runs one burst; cycle 0 carries the address strobe. Inputs change 1 after the edge.
    task automatic run(input logic early, input logic fixed, input logic wr,
                       input logic [ADDR_W-1:0] a, input logic [LAT_W-1:0] lat,
                       input int ncyc, input int bf, input int bt, input int ce_off,
                       input int adv2, input logic [ADDR_W-1:0] a2);
        cfg_wait_early = early;
        cfg_fixed_lat  = fixed;
        cfg_lat_cnt    = lat;
        for (int c = 0; c < ncyc; c++) begin
            tick();
            ce_n         = (c >= ce_off);
            adv_n        = !((c == 0) || (c == adv2));
            addr_i       = (c == adv2) ? a2 : a;
            we_n         = !wr;
            refresh_busy = (c >= bf) && (c < bt);
            #1;
            r_wait[c] = wait_o;
            r_rd[c]   = rd_valid_o;
            r_wr[c]   = wr_accept_o;
            r_addr[c] = data_addr_o;
        end
        tick();
        ce_n = 1'b1; adv_n = 1'b1; refresh_busy = 1'b0;
        tick();
        tick();
    endtask

    task automatic chk_span(input string req, input int from, input int to,
                            input logic w, input logic xr, input logic xw);
        for (int c = from; c <= to; c++) begin
            chk({req, " wait"}, c, 32'(r_wait[c]), 32'(w));
            chk({req, " rd"},   c, 32'(r_rd[c]),   32'(xr));
            chk({req, " wr"},   c, 32'(r_wr[c]),   32'(xw));
        end
    endtask

    task automatic t_reset();
        chk("R12 wait", 0, 32'(wait_o), 32'd0);
        chk("R12 rd",   0, 32'(rd_valid_o), 32'd0);
        chk("R12 wr",   0, 32'(wr_accept_o), 32'd0);
    endtask

    task automatic t_latency_read();
        run(0, 0, 0, 22'h10, 4'd3, 8, 99, 99, 99, 99, '0);
        chk_span("R1", 0, 0, 0, 0, 0);
        chk_span("R1", 1, 3, 1, 0, 0);
        chk_span("R2", 4, 7, 0, 1, 0);
        chk("R2 addr", 4, 32'(r_addr[4]), 32'h10);
        chk("R2 addr", 7, 32'(r_addr[7]), 32'h13);
    endtask

    task automatic t_latency_early();
        run(1, 0, 0, 22'h10, 4'd3, 8, 99, 99, 99, 99, '0);
        chk_span("R5", 0, 2, 1, 0, 0);
        chk_span("R5", 3, 3, 0, 0, 0);
        chk_span("R5", 4, 7, 0, 1, 0);
    endtask

    task automatic t_write();
        run(0, 0, 1, 22'h40, 4'd2, 6, 99, 99, 99, 99, '0);
        chk_span("R3", 1, 2, 1, 0, 0);
        chk_span("R3", 3, 5, 0, 0, 1);
    endtask

    task automatic t_var_refresh();
        run(0, 0, 0, 22'h10, 4'd2, 8, 1, 4, 99, 99, '0);
        chk_span("R4", 1, 5, 1, 0, 0);
        chk_span("R4", 6, 7, 0, 1, 0);
    endtask

    task automatic t_fixed_refresh();
        run(0, 1, 0, 22'h10, 4'd2, 6, 1, 4, 99, 99, '0);
        chk_span("R6", 1, 2, 1, 0, 0);
        chk_span("R6", 3, 5, 0, 1, 0);
    endtask

    task automatic t_row_cross();
        run(0, 0, 0, 22'h7E, 4'd2, 9, 99, 99, 99, 99, '0);
        chk_span("R7", 3, 4, 0, 1, 0);
        chk("R7 addr", 4, 32'(r_addr[4]), 32'h7F);
        chk_span("R7", 5, 6, 1, 0, 0);
        chk_span("R7", 7, 8, 0, 1, 0);
        chk("R7 addr", 7, 32'(r_addr[7]), 32'h80);
    endtask

    task automatic t_row_cross_early();
        run(1, 0, 0, 22'h7E, 4'd2, 9, 99, 99, 99, 99, '0);
        chk("R5 wait", 3, 32'(r_wait[3]), 32'd0);
        chk("R5 wait", 4, 32'(r_wait[4]), 32'd1);
        chk("R5 wait", 5, 32'(r_wait[5]), 32'd1);
        chk_span("R5", 6, 6, 0, 0, 0);
        chk_span("R5", 7, 8, 0, 1, 0);
    endtask

    task automatic t_row_refresh_fixed();
        run(0, 1, 0, 22'h7E, 4'd2, 11, 5, 7, 99, 99, '0);
        chk_span("R8", 5, 8, 1, 0, 0);
        chk_span("R8", 9, 10, 0, 1, 0);
        chk("R8 addr", 9, 32'(r_addr[9]), 32'h80);
    endtask

    task automatic t_ce_abort();
        run(0, 0, 0, 22'h10, 4'd3, 6, 99, 99, 2, 99, '0);
        chk_span("R9", 3, 5, 0, 0, 0);
    endtask

    task automatic t_restart();
        run(0, 0, 0, 22'h10, 4'd2, 9, 99, 99, 99, 4, 22'h200);
        chk("R10 addr", 4, 32'(r_addr[4]), 32'h11);
        chk_span("R10", 5, 6, 1, 0, 0);
        chk_span("R10", 7, 8, 0, 1, 0);
        chk("R10 addr", 7, 32'(r_addr[7]), 32'h200);
    endtask

    task automatic t_zero_lat();
        run(0, 0, 0, 22'h10, 4'd0, 4, 99, 99, 99, 99, '0);
        chk_span("R11", 1, 1, 1, 0, 0);
        chk_span("R11", 2, 3, 0, 1, 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 50000);
        n_vec++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; ce_n = 1'b1; adv_n = 1'b1; we_n = 1'b1; addr_i = '0;
        cfg_wait_early = 1'b0; cfg_fixed_lat = 1'b0; cfg_lat_cnt = 4'd3; refresh_busy = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_latency_read();
        t_latency_early();
        t_write();
        t_var_refresh();
        t_fixed_refresh();
        t_row_cross();
        t_row_cross_early();
        t_row_refresh_fixed();
        t_ce_abort();
        t_restart();
        t_zero_lat();
        finish_run();
    end
endmodule